// File: doc/BRIEF.md
# Dual-Edge Capture Timer

An up-counting timer whose count source is picked from an external input pin or one of three prescaler tick enables. The counter can either run freely, wrapping at its top value, or return to zero on reaching a programmable compare value. A one-cycle match flag marks each step taken from the compare value.

Two capture registers latch the running count on signal edges. One register takes rising edges and the other takes falling edges, so the difference between them is a pulse width in count units. The capture source is either the synchronised external pin or an internal timer output. A command bit in the mode register, written as 0, makes a software capture into the first register. An interrupt pulse follows each rising edge of the pin whenever hardware capture is enabled.

The mode register is 8 bits wide with this layout:
- bit 7: run
- bit 6: reserved
- bit 5: software-capture command (active low)
- bits 4:3: capture mode
- bit 2: clear enable
- bits 1:0: clock select

Top module: `cap_timer`

## Requirements
- R1: After reset the count, both capture values, match and irq are 0. The mode register holds 0x20: stopped, clearing off, capture off, pin clock. The compare value is all ones.
- R2: Clock select (mode bits 1:0) sets which source advances the counter, by one per event: 00 synchronised pin rising edge, 01 tick1, 10 tick4, 11 tick16. Events from the sources that are not selected have no effect.
- R3: With the run bit (mode bit 7) at 0, the count holds whatever the sources do. With it at 1, selected events advance the count.
- R4: With clear enable (mode bit 2) at 1, a step taken while count equals the compare value loads 0. Any step taken while count equals the compare value pulses match for one cycle, whether or not clear enable is set.
- R5: With clear enable at 0, the counter wraps from all ones to 0.
- R6: Capture mode 00 (mode bits 4:3) makes no hardware capture and raises no irq.
- R7: Capture mode 01 loads capture 0 on a pin rising edge and leaves capture 1 unchanged.
- R8: Capture mode 10 loads capture 0 on a pin rising edge and capture 1 on a pin falling edge.
- R9: Capture mode 11 loads capture 0 on a rising edge and capture 1 on a falling edge of the internal timer input. Pin edges capture nothing in this mode.
- R10: Every pin rising edge under a nonzero capture mode gives exactly one single-cycle irq pulse.
- R11: A mode write with bit 5 at 0 copies the count into capture 0 at that clock edge, taking priority over hardware capture.
- R12: A capture in the same cycle as a counter step or clear latches the count from before that step.
- R13: A mode write stores bits 7, 4:0. Bit 5 is always kept at 1 and bit 6 at 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick1 | input | 1 | Divide-by-1 prescaler enable |
| tick4 | input | 1 | Divide-by-4 prescaler enable |
| tick16 | input | 1 | Divide-by-16 prescaler enable |
| ext_pin | input | 1 | External asynchronous input |
| tmr_in | input | 1 | Internal timer output used as capture source |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CW | Compare value write data |
| count_o | output | CW | Running count |
| cap0_o | output | CW | Capture register 0 (rising / software) |
| cap1_o | output | CW | Capture register 1 (falling) |
| match_o | output | 1 | Compare-match step pulse |
| irq_o | output | 1 | Interrupt pulse on pin rise |

## Verification
The bench builds the block with its default 16-bit counter and two synchroniser stages. At that width a full wrap from any start value to zero is reached within the cycle budget. It sweeps all four clock selects against bursts of distinct lengths on every source, and all four capture modes against pin and internal edges. The clear-on-match period, the match pulse count and the capture-during-clear case are all computed arithmetically.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef struct packed {
    logic       run;
    logic       rsv;
    logic       swcap_n;
    logic [1:0] capmode;
    logic       clr_en;
    logic [1:0] clksel;
  } mode_t;

  localparam logic [7:0] MODE_RST = 8'h20;

  localparam logic [1:0] CAP_OFF   = 2'b00;
  localparam logic [1:0] CAP_RISE  = 2'b01;
  localparam logic [1:0] CAP_PIN2  = 2'b10;
  localparam logic [1:0] CAP_INT2  = 2'b11;

  localparam logic [1:0] CLK_PIN = 2'b00;
  localparam logic [1:0] CLK_T1  = 2'b01;
  localparam logic [1:0] CLK_T4  = 2'b10;
  localparam logic [1:0] CLK_T16 = 2'b11;
endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      rise   <= sync_q[STAGES-1] & ~prev_q;
      fall   <= ~sync_q[STAGES-1] & prev_q;
    end
  end
endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clr_en,
  input  logic [CW-1:0] cmp,
  output logic [CW-1:0] count,
  output logic          match
);
  logic at_cmp;
  assign at_cmp = (count == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      match <= 1'b0;
    end else begin
      match <= step & at_cmp;
      if (step) begin
        if (clr_en && at_cmp) count <= '0;
        else                  count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cap_timer_capture.sv
module cap_timer_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_cap,
  input  logic          trig0,
  input  logic          trig1,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap0,
  output logic [CW-1:0] cap1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap0 <= '0;
      cap1 <= '0;
    end else begin
      if (sw_cap || trig0) cap0 <= count;
      if (trig1)           cap1 <= count;
    end
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick1,
  input  logic          tick4,
  input  logic          tick16,
  input  logic          ext_pin,
  input  logic          tmr_in,
  input  logic          mode_we,
  input  logic [7:0]    mode_wdata,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] cap0_o,
  output logic [CW-1:0] cap1_o,
  output logic          match_o,
  output logic          irq_o
);
  mode_t         mode_q;
  logic [CW-1:0] cmp_q;
  logic          pin_rise, pin_fall, int_rise, int_fall;
  logic          src_evt, step, sw_cap, trig0, trig1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_t'(MODE_RST);
      cmp_q  <= '1;
    end else begin
      if (mode_we) begin
        mode_q         <= mode_t'(mode_wdata);
        mode_q.swcap_n <= 1'b1;
        mode_q.rsv     <= 1'b0;
      end
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  cap_timer_edge #(.STAGES(SYNC_STAGES)) u_pin_edge (
    .clk(clk), .rst(rst), .din(ext_pin), .rise(pin_rise), .fall(pin_fall));

  cap_timer_edge #(.STAGES(SYNC_STAGES)) u_int_edge (
    .clk(clk), .rst(rst), .din(tmr_in), .rise(int_rise), .fall(int_fall));

  always_comb begin
    case (mode_q.clksel)
      CLK_PIN: src_evt = pin_rise;
      CLK_T1:  src_evt = tick1;
      CLK_T4:  src_evt = tick4;
      default: src_evt = tick16;
    endcase
  end
  assign step = mode_q.run & src_evt;

  always_comb begin
    trig0 = 1'b0;
    trig1 = 1'b0;
    case (mode_q.capmode)
      CAP_RISE: trig0 = pin_rise;
      CAP_PIN2: begin
        trig0 = pin_rise;
        trig1 = pin_fall;
      end
      CAP_INT2: begin
        trig0 = int_rise;
        trig1 = int_fall;
      end
      default: ;
    endcase
  end
  assign sw_cap = mode_we & ~mode_wdata[5];

  cap_timer_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .step(step), .clr_en(mode_q.clr_en),
    .cmp(cmp_q), .count(count_o), .match(match_o));

  cap_timer_capture #(.CW(CW)) u_capture (
    .clk(clk), .rst(rst), .sw_cap(sw_cap), .trig0(trig0), .trig1(trig1),
    .count(count_o), .cap0(cap0_o), .cap1(cap1_o));

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pin_rise & (mode_q.capmode != CAP_OFF);
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input mode_t         mode_q,
  input logic [CW-1:0] cmp_q,
  input logic          step,
  input logic          mode_we,
  input logic [7:0]    mode_wdata,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cap0_o,
  input logic [CW-1:0] cap1_o,
  input logic          irq_o
);
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !mode_q.run |=> $stable(count_o));

  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (rst)
    (step && mode_q.clr_en && count_o == cmp_q) |=> (count_o == '0));

  a_r6_no_cap1_when_off: assert property (@(posedge clk) disable iff (rst)
    (mode_q.capmode == CAP_OFF || mode_q.capmode == CAP_RISE) |=> $stable(cap1_o));

  a_r10_irq_needs_capmode: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(mode_q.capmode) != CAP_OFF));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r11_sw_capture: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !mode_wdata[5]) |=> (cap0_o == $past(count_o)));

  a_r13_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (mode_q.swcap_n && !mode_q.rsv));
endmodule

bind cap_timer cap_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .cmp_q(cmp_q), .step(step),
  .mode_we(mode_we), .mode_wdata(mode_wdata), .count_o(count_o),
  .cap0_o(cap0_o), .cap1_o(cap1_o), .irq_o(irq_o));

// File: tb/cap_timer_test.sv
module cap_timer_test;
  localparam int PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick1 = 0, tick4 = 0, tick16 = 0, ext_pin = 0, tmr_in = 0;
  logic mode_we = 0, cmp_we = 0;
  logic [7:0] mode_wdata = 0;
  logic [CW-1:0] cmp_wdata = 0;
  logic [CW-1:0] count_o, cap0_o, cap1_o;
  logic match_o, irq_o;

  int checks = 0, fails = 0;
  int irq_seen = 0, match_seen = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cap_timer #(.CW(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .tick1(tick1), .tick4(tick4), .tick16(tick16),
    .ext_pin(ext_pin), .tmr_in(tmr_in), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .count_o(count_o), .cap0_o(cap0_o), .cap1_o(cap1_o),
    .match_o(match_o), .irq_o(irq_o));

  always @(negedge clk) if (!rst) begin
    if (irq_o) irq_seen++;
    if (match_o) match_seen++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit run, input bit [1:0] cm,
                                    input bit clr, input bit [1:0] cs);
    return {run, 1'b0, 1'b1, cm, clr, cs};
  endfunction

  task automatic wr_mode(input logic [7:0] v);
    mode_wdata = v; mode_we = 1;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_cmp(input logic [CW-1:0] v);
    cmp_wdata = v; cmp_we = 1;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      case (src)
        0: tick1 = 1;
        1: tick4 = 1;
        default: tick16 = 1;
      endcase
      @(negedge clk);
      tick1 = 0; tick4 = 0; tick16 = 0;
      @(negedge clk);
    end
  endtask

  task automatic set_pin(input logic v);
    ext_pin = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_int(input logic v);
    tmr_in = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] base, e0, e1;
    int irq_exp;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 cap0", cap0_o, 0);
    chk("R1 cap1", cap1_o, 0);
    chk("R1 irq+match", {irq_o, match_o}, 0);
    // R1: default mode is stopped with pin clock
    set_pin(1); set_pin(0);
    pulse(0, 2);
    chk("R1 stopped after reset", count_o, 0);

    // R2/R3/R6 sweep over clock selects
    for (int cs = 0; cs < 4; cs++) begin
      for (int run = 0; run < 2; run++) begin
        int exp_d;
        wr_mode(mk(run[0], 2'b00, 1'b0, cs[1:0]));
        base = count_o;
        irq_exp = irq_seen;
        pulse(0, 3); pulse(1, 5); pulse(2, 7);
        for (int k = 0; k < 2; k++) begin set_pin(1); set_pin(0); end
        case (cs)
          0: exp_d = 2;
          1: exp_d = 3;
          2: exp_d = 5;
          default: exp_d = 7;
        endcase
        if (run == 0) exp_d = 0;
        chk(run ? "R2 source select" : "R3 stopped", count_o - base, exp_d);
        chk("R6 no irq when capture off", irq_seen, irq_exp);
      end
    end
    chk("R6 caps untouched", {cap0_o, cap1_o}, 0);

    // R7/R8/R9/R10 sweep over capture modes
    e0 = cap0_o; e1 = cap1_o;
    for (int cm = 0; cm < 4; cm++) begin
      wr_mode(mk(1'b1, cm[1:0], 1'b0, 2'b01));
      base = count_o;
      irq_exp = irq_seen + ((cm != 0) ? 1 : 0);
      set_pin(1);
      if (cm == 1 || cm == 2) e0 = base;
      chk("R10 irq on pin rise", irq_seen, irq_exp);
      chk(cm == 1 ? "R7 rise cap0" : "R8 R9 rise cap0", cap0_o, e0);
      pulse(0, 2);
      set_pin(0);
      if (cm == 2) e1 = base + 2;
      chk(cm == 1 ? "R7 cap1 unchanged" : "R8 fall cap1", cap1_o, e1);
      set_int(1);
      if (cm == 3) e0 = base + 2;
      chk("R9 internal rise cap0", cap0_o, e0);
      pulse(0, 1);
      set_int(0);
      if (cm == 3) e1 = base + 3;
      chk("R9 internal fall cap1", cap1_o, e1);
      chk("R10 no irq from internal edges", irq_seen, irq_exp);
    end

    // R11/R13 software capture, mode bits
    pulse(0, 4);
    base = count_o;
    wr_mode(8'b0100_0001);  // run=0, bit6 set, swcap_n=0, capture off
    chk("R11 sw capture", cap0_o, base);
    pulse(0, 3);
    chk("R13 run cleared by write", count_o, base);
    wr_mode(mk(1'b1, 2'b11, 1'b0, 2'b01));
    set_int(1);
    base = count_o;
    tmr_in = 0;
    repeat (2) @(negedge clk);
    pulse(0, 1);
    wr_mode(8'b1001_1101 & 8'hDF); // sw capture while internal mode active
    chk("R11 sw capture value", cap0_o, base + 1);
    repeat (6) @(negedge clk);

    // R4 clear on match with period
    wr_mode(mk(1'b1, 2'b00, 1'b1, 2'b01));
    base = count_o;
    wr_cmp(base + 3);
    match_seen = 0;
    begin
      logic [CW-1:0] m;
      int mexp;
      m = base; mexp = 0;
      for (int i = 0; i < 13; i++) begin
        if (m == base + 3) begin m = 0; mexp++; end
        else m = m + 1;
      end
      pulse(0, 13);
      chk("R4 clear period", count_o, m);
      chk("R4 match pulses", match_seen, mexp);
    end
    // R4 match without clear
    wr_mode(mk(1'b1, 2'b00, 1'b0, 2'b01));
    wr_cmp(count_o);
    match_seen = 0;
    base = count_o;
    pulse(0, 2);
    chk("R4 match without clear", match_seen, 1);
    chk("R4 no clear when disabled", count_o, base + 2);

    // R12 capture with simultaneous step and clear (pin clock)
    wr_mode(mk(1'b1, 2'b10, 1'b1, 2'b00));
    base = count_o;
    wr_cmp(base + 1);
    set_pin(1); set_pin(0);
    chk("R12 capture pre-step", cap0_o, base);
    chk("R12 fall after step", cap1_o, base + 1);
    set_pin(1);
    chk("R12 capture pre-clear", cap0_o, base + 1);
    chk("R12 cleared", count_o, 0);
    set_pin(0);
    chk("R12 fall after clear", cap1_o, 0);

    // R5 wrap
    wr_mode(mk(1'b1, 2'b00, 1'b0, 2'b01));
    pulse(0, 5);
    base = count_o;
    tick1 = 1;
    repeat ((1 << CW) - int'(base)) @(negedge clk);
    tick1 = 0;
    @(negedge clk);
    chk("R5 wrap to zero", count_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule